// File: doc/BRIEF.md
# Mesh Corner Turn-Rule Manager

This controller sits in each router of a 2D mesh and owns the router's corner turn rule. A corner rule forbids the pair of 90-degree turns at one corner. By default that is the pair at the north-east corner, so that routing tables built by flag flooding cannot form deadlock loops. During a reconfiguration run, every router steps through the same global sequence of check slots. One slot belongs to each router index. In its own slot a router is the centre of its corner check. The corner is routed from one leg to the other with the rule still in force. If the centre does not see flags arrive from both corner neighbours, the rule is blocking connectivity, and the router lifts it, allowing both turns. Because only one router checks per slot, rules are relaxed one at a time and as few as possible are removed.

Lifting a rule can fold a loop through the relaxed router. To break it, the router originates a corner-change broadcast. From a north-east rule it sends a north-west change toward north and west. From a north-west rule it sends a north-east change toward north and east. A router that receives a change for a corner other than its own adopts the new corner, re-imposes the rule and forwards the change in that corner's directions. The re-imposed rule is then checked again in the next pass. Each router's slot returns once per pass, and a run lasts a fixed number of passes. A router whose rule was not touched during a whole pass becomes fixed. From then on it skips its checks and neither adopts nor forwards changes.

Top module: `corner_rule_mgr`

## Requirements
- R1: Reset state. After reset the turn mask is 8'h03: bit 0 (north-to-east) and bit 1 (east-to-north) are set, where a set bit means disallowed. The fixed flag is low, busy is low and all four change outputs are low.
- R2: Starting a run. A run_start pulse while idle raises busy on the next cycle. Busy stays high for N_PASS*N_ROUTERS*SLOT_LEN cycles. The same edge restores mask 8'h03 and clears fixed. A run_start while busy has no effect.
- R3: Slot sequencing. Run cycle c (counted from 0 at the first busy cycle) falls in slot (c/SLOT_LEN) mod N_ROUTERS. A router evaluates its check only in the slot equal to my_id, at that slot's last cycle.
- R4: Passing check. The check passes when leg_a_flag and leg_b_flag have each been high in at least one cycle of the router's own slot; the two may be in different cycles. A passing check leaves the mask unchanged.
- R5: Failing check. On a failing check by an imposed, non-fixed rule, the mask becomes 8'h00 in the cycle after the slot's last cycle. The mask only ever takes the values 8'h00, 8'h03 and 8'h0C.
- R6: Originating a change. In the cycle after a lift, the router pulses one change for the opposite corner. From a north-east rule it raises nw_to_n and nw_to_w; from a north-west rule it raises ne_to_n and ne_to_e. The north-east and north-west outputs are never high together.
- R7: Adopting a change. While busy, not fixed, and in a cycle with no lift, a change for the other corner takes effect on the next cycle. North-west changes arrive on nw_from_s or nw_from_e; north-east changes arrive on ne_from_s or ne_from_w. The router adopts the corner (north-west mask 8'h0C: bit 2 north-to-west, bit 3 west-to-north; north-east mask 8'h03), re-imposes the rule and pulses that corner's two outputs in the same cycle. A change for the router's current corner does nothing.
- R8: Becoming fixed. At the last cycle of each pass, a router whose rule was neither lifted nor re-cornered during that pass becomes fixed. A fixed router keeps its mask for the rest of the run, ignores changes, forwards nothing and never lifts.
- R9: Idle behaviour. While idle, flags and change inputs have no effect on the mask or the outputs.
- R10: Simultaneous changes. When north-east and north-west changes arrive in the same cycle, the north-east change is the one taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Begin a reconfiguration run (ignored while busy) |
| my_id | input | $clog2(N_ROUTERS) | This router's index in the global check order |
| leg_a_flag | input | 1 | Flag received from the first corner neighbour |
| leg_b_flag | input | 1 | Flag received from the second corner neighbour |
| ne_from_s | input | 1 | North-east change arriving from the south |
| ne_from_w | input | 1 | North-east change arriving from the west |
| nw_from_s | input | 1 | North-west change arriving from the south |
| nw_from_e | input | 1 | North-west change arriving from the east |
| turn_block | output | 8 | Disallowed-turn mask, one bit per 90-degree turn |
| rule_fixed | output | 1 | Rule frozen for the rest of the run |
| run_busy | output | 1 | Reconfiguration run in progress |
| ne_to_n | output | 1 | North-east change sent north |
| ne_to_e | output | 1 | North-east change sent east |
| nw_to_n | output | 1 | North-west change sent north |
| nw_to_w | output | 1 | North-west change sent west |

## Verification
The router is driven through several kinds of run:
- Both leg flags arrive in separate cycles of the own slot. This separates a kept rule from a lifted one and shows the router fixing itself after one quiet pass.
- Only one leg flag arrives. This checks that a half-routed corner counts as a failure.
- Changes arrive toward the north-west, then back toward the north-east. This shows adoption, forwarding and re-checking.
- A repeated same-corner change and a simultaneous pair of changes. These separate the no-op case from the priority case.
- Changes and a lift from the north-west corner are sent to a fixed router, to the idle block and during a run. These check that fixing, idling and the corner being left each select the right behaviour.

// File: rtl/turnrule_pkg.sv
package turnrule_pkg;

    typedef enum logic {
        CRN_NE = 1'b0,
        CRN_NW = 1'b1
    } corner_e;

    localparam int TURN_BITS = 8;

    // Turn bit positions in the disallow mask
    localparam int T_N2E = 0;
    localparam int T_E2N = 1;
    localparam int T_N2W = 2;
    localparam int T_W2N = 3;

    typedef struct packed {
        logic ne_n;
        logic ne_e;
        logic nw_n;
        logic nw_w;
    } chg_out_t;

    function automatic logic [TURN_BITS-1:0] corner_turns(corner_e c);
        logic [TURN_BITS-1:0] m;
        m = '0;
        if (c == CRN_NE) begin
            m[T_N2E] = 1'b1;
            m[T_E2N] = 1'b1;
        end else begin
            m[T_N2W] = 1'b1;
            m[T_W2N] = 1'b1;
        end
        return m;
    endfunction

    function automatic chg_out_t corner_send(corner_e c);
        chg_out_t s;
        s = '0;
        if (c == CRN_NE) begin
            s.ne_n = 1'b1;
            s.ne_e = 1'b1;
        end else begin
            s.nw_n = 1'b1;
            s.nw_w = 1'b1;
        end
        return s;
    endfunction

    function automatic corner_e other_corner(corner_e c);
        return (c == CRN_NE) ? CRN_NW : CRN_NE;
    endfunction

endpackage

// File: rtl/crm_slot_seq.sv
module crm_slot_seq #(
    parameter int N_ROUTERS = 9,
    parameter int SLOT_LEN  = 4,
    parameter int N_PASS    = 3,
    parameter int IDW       = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           busy,
    output logic [IDW-1:0] slot,
    output logic           slot_last,
    output logic           pass_end
);
    localparam int CW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int PW = (N_PASS > 1) ? $clog2(N_PASS) : 1;

    logic [CW-1:0] cyc;
    logic [PW-1:0] pass;

    assign slot_last = busy && (cyc == CW'(SLOT_LEN - 1));
    assign pass_end  = slot_last && (slot == IDW'(N_ROUTERS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cyc  <= '0;
            slot <= '0;
            pass <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cyc  <= '0;
                slot <= '0;
                pass <= '0;
            end
        end else if (slot_last) begin
            cyc <= '0;
            if (pass_end) begin
                slot <= '0;
                if (pass == PW'(N_PASS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    pass <= pass + 1'b1;
                end
            end else begin
                slot <= slot + 1'b1;
            end
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/crm_corner_check.sv
module crm_corner_check (
    input  logic clk,
    input  logic rst,
    input  logic own,
    input  logic slot_last,
    input  logic flag_a,
    input  logic flag_b,
    output logic fail
);
    logic seen_a, seen_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end else if (own && !slot_last) begin
            seen_a <= seen_a | flag_a;
            seen_b <= seen_b | flag_b;
        end else begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
        end
    end

    assign fail = own && slot_last && !((seen_a | flag_a) && (seen_b | flag_b));
endmodule

// File: rtl/crm_bcast.sv
module crm_bcast
    import turnrule_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  logic     fixed,
    input  corner_e  corner,
    input  logic     lift,
    input  logic     ne_in,
    input  logic     nw_in,
    output logic     hit,
    output corner_e  target,
    output chg_out_t send
);
    // North-east requests win when both arrive together
    assign target = ne_in ? CRN_NE : CRN_NW;
    assign hit    = busy && !fixed && !lift && (ne_in || nw_in) && (target != corner);

    always_ff @(posedge clk) begin
        if (rst) begin
            send <= '0;
        end else if (busy && lift) begin
            send <= corner_send(other_corner(corner));
        end else if (hit) begin
            send <= corner_send(target);
        end else begin
            send <= '0;
        end
    end
endmodule

// File: rtl/corner_rule_mgr.sv
module corner_rule_mgr
    import turnrule_pkg::*;
#(
    parameter int N_ROUTERS = 9,
    parameter int SLOT_LEN  = 4,
    parameter int N_PASS    = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run_start,
    input  logic [$clog2(N_ROUTERS)-1:0] my_id,
    input  logic                         leg_a_flag,
    input  logic                         leg_b_flag,
    input  logic                         ne_from_s,
    input  logic                         ne_from_w,
    input  logic                         nw_from_s,
    input  logic                         nw_from_e,
    output logic [7:0]                   turn_block,
    output logic                         rule_fixed,
    output logic                         run_busy,
    output logic                         ne_to_n,
    output logic                         ne_to_e,
    output logic                         nw_to_n,
    output logic                         nw_to_w
);
    localparam int IDW = $clog2(N_ROUTERS);

    logic           busy, slot_last, pass_end, own, fail, lift, hit;
    logic [IDW-1:0] slot;
    corner_e        corner, target;
    logic           imposed, modified, mod_nxt;
    chg_out_t       send;

    crm_slot_seq #(
        .N_ROUTERS(N_ROUTERS), .SLOT_LEN(SLOT_LEN), .N_PASS(N_PASS), .IDW(IDW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(run_start), .busy(busy),
        .slot(slot), .slot_last(slot_last), .pass_end(pass_end)
    );

    assign own = busy && (slot == my_id);

    crm_corner_check u_chk (
        .clk(clk), .rst(rst), .own(own), .slot_last(slot_last),
        .flag_a(leg_a_flag), .flag_b(leg_b_flag), .fail(fail)
    );

    assign lift = fail && imposed && !rule_fixed;

    crm_bcast u_bc (
        .clk(clk), .rst(rst), .busy(busy), .fixed(rule_fixed), .corner(corner),
        .lift(lift), .ne_in(ne_from_s | ne_from_w), .nw_in(nw_from_s | nw_from_e),
        .hit(hit), .target(target), .send(send)
    );

    assign mod_nxt = modified | lift | hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            corner     <= CRN_NE;
            imposed    <= 1'b1;
            rule_fixed <= 1'b0;
            modified   <= 1'b0;
        end else if (!busy) begin
            if (run_start) begin
                corner     <= CRN_NE;
                imposed    <= 1'b1;
                rule_fixed <= 1'b0;
                modified   <= 1'b0;
            end
        end else begin
            if (lift) begin
                imposed <= 1'b0;
            end else if (hit) begin
                corner  <= target;
                imposed <= 1'b1;
            end
            if (pass_end) begin
                rule_fixed <= rule_fixed | ~mod_nxt;
                modified   <= 1'b0;
            end else begin
                modified <= mod_nxt;
            end
        end
    end

    assign turn_block = imposed ? corner_turns(corner) : '0;
    assign run_busy   = busy;
    assign ne_to_n    = send.ne_n;
    assign ne_to_e    = send.ne_e;
    assign nw_to_n    = send.nw_n;
    assign nw_to_w    = send.nw_w;
endmodule

// File: rtl/corner_rule_chk.sv
module corner_rule_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] turn_block,
    input logic       rule_fixed,
    input logic       run_busy,
    input logic       ne_to_n,
    input logic       ne_to_e,
    input logic       nw_to_n,
    input logic       nw_to_w
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (turn_block == 8'h03 && !rule_fixed && !run_busy));

    assert_run_entry_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(run_busy) |-> (turn_block == 8'h03 && !rule_fixed));

    assert_mask_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (turn_block == 8'h00 || turn_block == 8'h03 || turn_block == 8'h0C));

    assert_one_corner_out_R6: assert property (@(posedge clk) disable iff (rst)
        !((ne_to_n || ne_to_e) && (nw_to_n || nw_to_w)));

    assert_fixed_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (run_busy && rule_fixed) |=> rule_fixed);

    assert_fixed_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run_busy && $past(run_busy) && $past(rule_fixed)) |-> $stable(turn_block));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!run_busy && !$past(run_busy)) |-> !(ne_to_n || ne_to_e || nw_to_n || nw_to_w));
endmodule

bind corner_rule_mgr corner_rule_chk u_rule_chk (
    .clk(clk), .rst(rst), .turn_block(turn_block), .rule_fixed(rule_fixed),
    .run_busy(run_busy), .ne_to_n(ne_to_n), .ne_to_e(ne_to_e),
    .nw_to_n(nw_to_n), .nw_to_w(nw_to_w)
);

// File: tb/sim_corner_rule_mgr.sv
module sim_corner_rule_mgr;
    localparam int NR = 9;
    localparam int SL = 4;
    localparam int NP = 3;
    localparam int ID = 4;
    localparam int TOTAL = NR * SL * NP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_start = 1'b0;
    logic fa = 1'b0, fb = 1'b0;
    logic ne_s = 1'b0, ne_w = 1'b0, nw_s = 1'b0, nw_e = 1'b0;
    logic [7:0] turn_block;
    logic rule_fixed, run_busy, ne_to_n, ne_to_e, nw_to_n, nw_to_w;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    corner_rule_mgr #(.N_ROUTERS(NR), .SLOT_LEN(SL), .N_PASS(NP)) u0 (
        .clk(clk), .rst(rst), .run_start(run_start), .my_id(4'(ID)),
        .leg_a_flag(fa), .leg_b_flag(fb),
        .ne_from_s(ne_s), .ne_from_w(ne_w), .nw_from_s(nw_s), .nw_from_e(nw_e),
        .turn_block(turn_block), .rule_fixed(rule_fixed), .run_busy(run_busy),
        .ne_to_n(ne_to_n), .ne_to_e(ne_to_e), .nw_to_n(nw_to_n), .nw_to_w(nw_to_w)
    );

    // Behavioural reference model
    int   m_t;
    bit   m_busy, m_nw, m_imp, m_fixed, m_mod, m_sa, m_sb;
    logic [3:0] m_out;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_nw = 0; m_imp = 1; m_fixed = 0; m_mod = 0;
            m_sa = 0; m_sb = 0; m_out = 4'b0; m_t = 0;
        end else if (!m_busy) begin
            m_out = 4'b0;
            if (run_start) begin
                m_busy = 1; m_t = 0; m_nw = 0; m_imp = 1; m_fixed = 0; m_mod = 0;
            end
        end else begin
            int slot_n, cyc_n;
            bit own, last, lift, hit, tgt_nw, modn;
            slot_n = (m_t / SL) % NR;
            cyc_n  = m_t % SL;
            own  = (slot_n == ID);
            last = (cyc_n == SL - 1);
            lift = own && last && m_imp && !m_fixed && !((m_sa | fa) && (m_sb | fb));
            tgt_nw = !(ne_s | ne_w);
            hit  = (ne_s | ne_w | nw_s | nw_e) && !m_fixed && !lift && (tgt_nw != m_nw);
            if (own && !last) begin m_sa = m_sa | fa; m_sb = m_sb | fb; end
            else begin m_sa = 0; m_sb = 0; end
            if (lift)     m_out = m_nw ? 4'b1100 : 4'b0011;
            else if (hit) m_out = tgt_nw ? 4'b0011 : 4'b1100;
            else          m_out = 4'b0;
            modn = m_mod | lift | hit;
            if (lift) m_imp = 0;
            else if (hit) begin m_nw = tgt_nw; m_imp = 1; end
            if (last && slot_n == NR - 1) begin
                if (!modn) m_fixed = 1;
                m_mod = 0;
            end else m_mod = modn;
            m_t++;
            if (m_t == TOTAL) m_busy = 0;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            logic [7:0] em;
            em = m_imp ? (m_nw ? 8'h0C : 8'h03) : 8'h00;
            chk(turn_block == em, "R5 mask", turn_block, em);
            chk(rule_fixed == m_fixed, "R8 fixed", rule_fixed, m_fixed);
            chk(run_busy == m_busy, "R2 busy", run_busy, m_busy);
            chk({ne_to_n, ne_to_e, nw_to_n, nw_to_w} == m_out, "R6 change outputs",
                {ne_to_n, ne_to_e, nw_to_n, nw_to_w}, m_out);
        end
    end

    // Drive one cycle's inputs
    task automatic cyc(bit rs, bit a, bit b, bit n_s, bit n_w, bit w_s, bit w_e);
        @(negedge clk); #1;
        run_start = rs; fa = a; fb = b;
        ne_s = n_s; ne_w = n_w; nw_s = w_s; nw_e = w_e;
    endtask

    // Scenario B: flags pass, router fixes, later change ignored
    task automatic scn_keep();
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < TOTAL + 2; c++) begin
            cyc(0, c == 16, c == 18, 0, 0, c == 40, 0);
            if (c == 20) chk(turn_block == 8'h03, "R4 passing check keeps rule", turn_block, 8'h03);
            if (c == 36) chk(rule_fixed == 1'b1, "R8 fixed after quiet pass", rule_fixed, 1);
            if (c == 41) chk(!nw_to_n && turn_block == 8'h03, "R8 fixed ignores change", turn_block, 8'h03);
        end
    endtask

    // Scenario C: one leg only, lift from NE, run_start while busy ignored
    task automatic scn_lift();
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < TOTAL + 2; c++) begin
            cyc(c == 50, c == 17, 0, 0, 0, 0, 0);
            if (c == 0)  chk(turn_block == 8'h03 && !rule_fixed, "R2 run entry", turn_block, 8'h03);
            if (c == 19) chk(turn_block == 8'h03, "R3 no change before own slot end", turn_block, 8'h03);
            if (c == 20) chk(turn_block == 8'h00, "R5 lift after failing check", turn_block, 8'h00);
            if (c == 20) chk(nw_to_n && nw_to_w, "R6 NW change from NE lift",
                             {nw_to_n, nw_to_w}, 2'b11);
            if (c == 52) chk(run_busy && turn_block == 8'h00, "R2 start ignored while busy",
                             turn_block, 8'h00);
        end
    endtask

    // Scenario D: corner changes, repeat, simultaneous, late lift
    task automatic scn_flip();
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < TOTAL + 2; c++) begin
            cyc(0, c == 16 || c == 52, c == 16 || c == 52,
                c == 46, c == 40, c == 5 || c == 44 || c == 46, c == 10);
            if (c == 6)  chk(turn_block == 8'h0C && nw_to_n && nw_to_w, "R7 adopt NW",
                             turn_block, 8'h0C);
            if (c == 11) chk(!nw_to_n && turn_block == 8'h0C, "R7 same corner no-op",
                             turn_block, 8'h0C);
            if (c == 41) chk(turn_block == 8'h03 && ne_to_n && ne_to_e, "R7 back to NE",
                             turn_block, 8'h03);
            if (c == 47) chk(turn_block == 8'h03 && ne_to_e, "R10 NE wins", turn_block, 8'h03);
            if (c == 92) chk(turn_block == 8'h00, "R5 late lift", turn_block, 8'h00);
        end
    endtask

    // Scenario G: lift while on NW corner
    task automatic scn_nw_lift();
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < TOTAL + 2; c++) begin
            cyc(0, 0, 0, 0, c == 40, c == 5, 0);
            if (c == 20) chk(ne_to_n && ne_to_e && turn_block == 8'h00, "R6 NE change from NW lift",
                             {ne_to_n, ne_to_e}, 2'b11);
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(turn_block == 8'h03, "R1 reset mask", turn_block, 8'h03);
        chk(!rule_fixed && !run_busy, "R1 reset status", {rule_fixed, run_busy}, 0);
        chk({ne_to_n, ne_to_e, nw_to_n, nw_to_w} == 4'b0, "R1 reset outputs",
            {ne_to_n, ne_to_e, nw_to_n, nw_to_w}, 0);
        cmp_on = 1'b1;
        scn_keep();
        scn_lift();
        // R9: idle stimulus on a lifted rule
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, 1, 1);
        chk(turn_block == 8'h00 && !nw_to_n, "R9 idle ignores inputs", turn_block, 8'h00);
        cyc(0, 0, 0, 0, 0, 0, 0);
        scn_flip();
        scn_nw_lift();
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule